// File: doc/BRIEF.md
# Store-Versus-Instruction Line Window

This block keeps a window of the cache-line tags of every instruction that has been fetched but not yet retired. Fetch presents the address of each instruction in program order, and the block stores its line tag in a circular window of entries. Retirement releases the oldest entry. Every data store, cacheable or not, presents its address. Its line tag is compared in parallel against all live entries. A match means a store may have rewritten an instruction already in flight, and the block raises a flush request in that same cycle.

On the clock edge that ends a cycle with a flush request, the window empties. All entries become invalid and both pointers return to zero. The surrounding flush and refetch machinery then refills the window from scratch. The window reports its occupancy and a full flag. Fetch must stall while the window is full. An allocation offered anyway is dropped and marked with an error pulse.

Top module: `smc_tag_window`

## Requirements
- R1: The line tag of an address is bits [31:5] (32-byte lines). A store matches an entry when these bits are equal, whatever bits [4:0] hold. A store that differs only in bit 5 does not match.
- R2: An accepted allocation writes the next entry in circular order and raises occupancy by one. `full` is 1 exactly when occupancy is 16. Entries stay tracked across pointer wraparound.
- R3: A retire releases the oldest live entry and lowers occupancy by one. A store to a released line no longer flushes.
- R4: `flush_req` is 1 in the same cycle as `store_valid` when the store matches a live entry. It is 0 when the store misses, when `store_valid` is 0, or when the window is empty.
- R5: A store is compared only against entries that were live before the current cycle. A store to the line being allocated in the same cycle does not flush.
- R6: A store that matches the entry being retired in the same cycle still raises `flush_req`.
- R7: After a cycle with `flush_req`, occupancy is 0 and no earlier entry matches. An allocate or retire in that same cycle is discarded.
- R8: While `full` is 1, an allocation is ignored: occupancy stays 16, the line is not tracked, and `alloc_err` is 1 in that cycle.
- R9: A retire while occupancy is 0 is ignored. An allocate and a retire together on an empty window give occupancy 1.
- R10: After reset, occupancy is 0 and `full`, `flush_req` and `alloc_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Fetch offers an instruction this cycle |
| alloc_addr | input | 32 | Fetch address of that instruction |
| retire_valid | input | 1 | Oldest instruction retires this cycle |
| store_valid | input | 1 | A data store is checked this cycle |
| store_addr | input | 32 | Byte address of the store |
| flush_req | output | 1 | Store matched an in-flight line; pipeline must flush |
| full | output | 1 | Window holds 16 entries |
| occupancy | output | 5 | Number of live entries |
| alloc_err | output | 1 | Allocation offered while full and dropped |

## Verification
The bench goes after the cycle-ordering corners. A design that compared against the entry it was writing would flush when a store hits a same-cycle allocation. A design that released the entry before comparing would miss a store that hits a retiring instruction. The bench also fills the window, pushes an extra allocation and checks that a store to that dropped line stays silent. A design that overwrote the oldest entry, or advanced past full, would show the wrong occupancy or a false flush there. It also checks wraparound and the tag boundary at bit 5. An off-by-one in the offset width would flush on a neighbouring line, or miss a store to another byte of the same line.

// File: rtl/smc_pkg.sv
package smc_pkg;
  parameter int unsigned SMC_ADDR_W     = 32;
  parameter int unsigned SMC_LINE_BYTES = 32;
  parameter int unsigned SMC_DEPTH      = 16;

  // Per-cycle pointer actions, already qualified by full/empty/flush priority
  typedef struct packed {
    logic flush;
    logic alloc;
    logic retire;
  } smc_ctl_t;
endpackage

// File: rtl/smc_ptr_ctrl.sv
module smc_ptr_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned DEPTH = SMC_DEPTH,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  smc_ctl_t         ctl,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (ctl.flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (ctl.alloc)  head_d = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
      if (ctl.retire) tail_d = (tail_q == LAST_IDX) ? '0 : tail_q + 1'b1;
      case ({ctl.alloc, ctl.retire})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  // Distance between pointers, used only for checking
  logic [CNT_W-1:0] gap;
  always_comb begin
    if (head_q >= tail_q) gap = CNT_W'(head_q - tail_q);
    else                  gap = CNT_W'(DEPTH) - CNT_W'(tail_q) + CNT_W'(head_q);
  end

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != FULL_CNT) |-> (gap == cnt_q));                        // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);                                              // R8
  AST_FLUSH_RESET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> (head_q == '0 && tail_q == '0));                   // R7
endmodule

// File: rtl/smc_tag_entry.sv
module smc_tag_entry #(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic             flush,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             valid_o,
  output logic             hit_o
);
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] tag_q;

  always_comb begin
    vld_d = vld_q;
    if (flush)       vld_d = 1'b0;
    else if (set_en) vld_d = 1'b1;
    else if (clr_en) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Tag storage: data register, enable only, no reset
  always_ff @(posedge clk) begin
    if (set_en && !flush) tag_q <= tag_in;
  end

  assign valid_o = vld_q;
  assign hit_o   = vld_q && (tag_q == probe_tag);

  AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush) |=> valid_o);                                 // R2
  AST_ENTRY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid_o);                                             // R7
  AST_ENTRY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !valid_o);                               // R3
endmodule

// File: rtl/smc_tag_window.sv
module smc_tag_window
  import smc_pkg::*;
#(
  parameter int unsigned ADDR_W     = SMC_ADDR_W,
  parameter int unsigned LINE_BYTES = SMC_LINE_BYTES,
  parameter int unsigned DEPTH      = SMC_DEPTH,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFS_W,
  localparam int unsigned PTR_W     = $clog2(DEPTH),
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              retire_valid,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  output logic              flush_req,
  output logic              full,
  output logic [CNT_W-1:0]  occupancy,
  output logic              alloc_err
);
  logic [TAG_W-1:0] alloc_tag, store_tag;
  logic [PTR_W-1:0] head, tail;
  logic             empty;
  logic [DEPTH-1:0] valid_vec, hit_vec;
  smc_ctl_t         ctl;

  assign alloc_tag = alloc_addr[ADDR_W-1:OFS_W];
  assign store_tag = store_addr[ADDR_W-1:OFS_W];

  logic unused_ofs;
  assign unused_ofs = ^{alloc_addr[OFS_W-1:0], store_addr[OFS_W-1:0]};

  // Compare uses only entries registered before this edge
  assign flush_req = store_valid && (|hit_vec);
  assign alloc_err = alloc_valid && full;

  assign ctl.flush  = flush_req;
  assign ctl.alloc  = alloc_valid && !full && !flush_req;
  assign ctl.retire = retire_valid && !empty && !flush_req;

  smc_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .head  (head),
    .tail  (tail),
    .count (occupancy),
    .full  (full),
    .empty (empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    smc_tag_entry #(.TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (ctl.alloc && (head == PTR_W'(i))),
      .clr_en    (ctl.retire && (tail == PTR_W'(i))),
      .flush     (flush_req),
      .tag_in    (alloc_tag),
      .probe_tag (store_tag),
      .valid_o   (valid_vec[i]),
      .hit_o     (hit_vec[i])
    );
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == int'(occupancy));                       // R2
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !flush_req);                               // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (occupancy == '0 && valid_vec == '0));             // R7
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !retire_valid && !flush_req) |=> full);                 // R8
  AST_EMPTY_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !alloc_valid && !flush_req) |=> (occupancy == '0));    // R9
endmodule

// File: tb/smc_tag_window_test.sv
module smc_tag_window_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, retire_valid = 1'b0, store_valid = 1'b0;
  logic [31:0] alloc_addr = '0, store_addr = '0;
  logic        flush_req, full, alloc_err;
  logic [4:0]  occupancy;

  int checks = 0, fails = 0;
  logic fl_s, err_s;

  always #2 clk = ~clk;   // 250 MHz

  smc_tag_window uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .retire_valid(retire_valid), .store_valid(store_valid), .store_addr(store_addr),
    .flush_req(flush_req), .full(full), .occupancy(occupancy), .alloc_err(alloc_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive after falling edge, capture combinational outputs,
  // let the rising edge pass, settle 1 ns for registered outputs.
  task automatic step(input logic av, input logic [31:0] aa, input logic rv,
                      input logic sv, input logic [31:0] sa);
    @(negedge clk);
    alloc_valid = av; alloc_addr = aa; retire_valid = rv;
    store_valid = sv; store_addr = sa;
    #1;
    fl_s = flush_req; err_s = alloc_err;
    @(posedge clk); #1;
    alloc_valid = 0; retire_valid = 0; store_valid = 0;
  endtask

  task automatic t_reset;
    chk("R10 occupancy", int'(occupancy), 0);
    chk("R10 full", int'(full), 0);
    chk("R10 flush_req", int'(flush_req), 0);
    chk("R10 alloc_err", int'(alloc_err), 0);
  endtask

  task automatic t_tag;
    step(1, 32'h1000_0040, 0, 0, 0);
    chk("R2 occupancy after one alloc", int'(occupancy), 1);
    step(0, 0, 0, 1, 32'h1000_0060);
    chk("R1 bit5 differs no flush", int'(fl_s), 0);
    step(0, 0, 0, 0, 32'h1000_0040);
    chk("R4 store_valid low no flush", int'(fl_s), 0);
    step(0, 0, 0, 1, 32'h1000_005F);
    chk("R1 R4 same line other byte flushes", int'(fl_s), 1);
    chk("R7 occupancy after flush", int'(occupancy), 0);
    step(0, 0, 0, 1, 32'h1000_0040);
    chk("R7 old entry gone", int'(fl_s), 0);
    step(1, 32'h1000_0040, 0, 0, 0);
    step(1, 32'h1000_0100, 1, 1, 32'h1000_0044);
    chk("R7 flush with alloc+retire", int'(fl_s), 1);
    chk("R7 same-cycle alloc discarded", int'(occupancy), 0);
  endtask

  task automatic t_same_cycle;
    step(1, 32'h4000_0080, 0, 1, 32'h4000_0080);
    chk("R5 same-cycle alloc not compared", int'(fl_s), 0);
    chk("R5 alloc accepted", int'(occupancy), 1);
    step(0, 0, 0, 1, 32'h4000_0080);
    chk("R4 next-cycle store flushes", int'(fl_s), 1);
  endtask

  task automatic t_empty_retire;
    step(0, 0, 1, 0, 0);
    chk("R9 retire on empty ignored", int'(occupancy), 0);
    step(1, 32'h5000_0000, 1, 0, 0);
    chk("R9 alloc+retire on empty", int'(occupancy), 1);
    step(0, 0, 0, 1, 32'h5000_0010);
    chk("R9 entry kept", int'(fl_s), 1);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) step(1, 32'h2000_0000 + 32'(i * 32), 0, 0, 0);
    chk("R2 occupancy full", int'(occupancy), 16);
    chk("R2 full flag", int'(full), 1);
    step(1, 32'h3000_0000, 0, 0, 0);
    chk("R8 alloc_err while full", int'(err_s), 1);
    chk("R8 occupancy unchanged", int'(occupancy), 16);
    step(0, 0, 0, 1, 32'h3000_0000);
    chk("R8 refused line not tracked", int'(fl_s), 0);
    step(0, 0, 1, 0, 0);
    chk("R3 retire lowers occupancy", int'(occupancy), 15);
    chk("R3 full drops", int'(full), 0);
    step(0, 0, 0, 1, 32'h2000_0004);
    chk("R3 retired line no flush", int'(fl_s), 0);
    step(0, 0, 1, 1, 32'h2000_0020);
    chk("R6 hit on retiring entry flushes", int'(fl_s), 1);
    chk("R7 emptied after flush", int'(occupancy), 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 10; i++) step(1, 32'h6000_0000 + 32'(i * 32), 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0);
    chk("R3 all retired", int'(occupancy), 0);
    for (int i = 0; i < 10; i++) step(1, 32'h7000_0000 + 32'(i * 32), 0, 0, 0);
    chk("R2 occupancy after wrap", int'(occupancy), 10);
    step(0, 0, 0, 1, 32'h6000_0120);
    chk("R3 old batch released", int'(fl_s), 0);
    step(0, 0, 0, 1, 32'h7000_0120);
    chk("R2 wrapped entry tracked", int'(fl_s), 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    t_reset();
    t_tag();
    t_same_cycle();
    t_empty_retire();
    t_fill();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule